// File: doc/BRIEF.md
# Saturating Rounding Narrowing Shifter

This block is a SIMD datapath unit. It takes a 128-bit source vector and turns each signed element into one half its width. Each element is shifted right arithmetically by an immediate amount, with rounding. The shifted value is then clamped to the signed range of the narrow width. A single packed immediate sets both the element size and the shift amount. It is split into a 4-bit size/shift field and a 3-bit fine field.

In vector mode the 64-bit narrowed result goes to one of two places. With the half-select bit clear, it goes to the low half of the destination and the high half is zeroed. With the half-select bit set, it goes to the high half and the low half keeps the old destination value. In scalar mode only the lowest source element is processed, and its result is zero-extended.

Reserved encodings raise an illegal flag and leave the destination unchanged. A sticky saturation bit records that some lane was clamped. Only a synchronous clear input or reset lowers this bit. Every result is registered one cycle after the input strobe.

Top module: `narrow_shift_unit`

## Requirements
- R1: The narrow size E comes from the highest set bit of sizeImm[2:0]: 001 gives 8, 01x gives 16, 1xx gives 32. Source lanes are 2E bits wide, lane k sits at srcVec[2E*k +: 2E], and result lane k sits at bits [E*k +: E] of the 64-bit narrowed value. The shift amount is 2E minus the unsigned value of {sizeImm, fracImm}.
- R2: When sizeImm is 0000 or sizeImm[3] is 1, an accepted operation sets badEnc to 1. In that case dstVec equals oldDst, satNow is 0 and satSticky does not change. A legal operation sets badEnc to 0.
- R3: Each lane is rounded to nearest with ties going up: 2^(shift-1) is added to the signed element, then it is shifted right arithmetically.
- R4: The rounded value is clamped to [-2^(E-1), 2^(E-1)-1]. A value that fits exactly, such as -128 for E=8, is not counted as saturation.
- R5: satNow is 1 when any processed lane of the operation was clamped. satSticky becomes 1 after such an operation and stays 1 through later operations that do not clamp.
- R6: When satClear is 1 at a clock edge, satSticky is 0 after that edge, even if a clamping operation is accepted at the same edge. The reset value of satSticky is 0.
- R7: In vector mode with upperSel 0, dstVec[63:0] is the narrowed result and dstVec[127:64] is zero.
- R8: In vector mode with upperSel 1, dstVec[127:64] is the narrowed result and dstVec[63:0] equals oldDst[63:0].
- R9: In scalar mode only the low 2E source bits are used. dstVec holds that single E-bit result zero-extended to 128 bits. Other lanes and upperSel have no effect on dstVec or on saturation.
- R10: The outputs are registered. outValid is high exactly one cycle after inValid. dstVec, badEnc and satNow hold their values while no operation is accepted.
- R11: After reset, outValid, badEnc, satNow and satSticky are 0 and dstVec is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| srcVec | input | 128 | Source vector of wide elements |
| sizeImm | input | 4 | Size/shift immediate field |
| fracImm | input | 3 | Fine shift immediate field |
| upperSel | input | 1 | Vector mode: write high half (1) or low half (0) |
| scalarMode | input | 1 | 1 = single element, 0 = vector |
| oldDst | input | 128 | Previous destination value |
| satClear | input | 1 | Clears the sticky saturation bit |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| dstVec | output | 128 | New destination value |
| badEnc | output | 1 | Reserved encoding flag |
| satNow | output | 1 | Saturation occurred in this operation |
| satSticky | output | 1 | Sticky saturation bit |

## Verification
A wrong size decode or shift calculation shows up as wrong lane values in dstVec one cycle after the strobe. The vectors use different sizes and shift extremes so that each decode path gives a distinct output. A faulty clamp comparison shows up in dstVec and in satNow on that same cycle. This is tested at both edges of the 8-bit range. The sticky bit is a state that carries across operations, so the bench keeps its own running model of it and compares satSticky after every operation. An error there can appear many operations after its cause, for example when a reserved encoding or a simultaneous clear is handled wrongly.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 3;
  localparam int SEL_N     = 4;
  localparam int SHIFT_W   = 6;
  localparam int IMM_W     = 7;

  typedef struct packed {
    logic               legal;
    logic [1:0]         sizeIdx;
    logic [SHIFT_W-1:0] shiftAmt;
    logic               upper;
    logic               scalar;
  } nsuCtrl_t;
endpackage

// File: rtl/nsu_lane.sv
module nsu_lane #(
  parameter int NARROW_W = 8,
  parameter int SHIFT_W  = 6
) (
  input  logic [2*NARROW_W-1:0] wideElt,
  input  logic [SHIFT_W-1:0]    shiftAmt,
  output logic [NARROW_W-1:0]   narrowElt,
  output logic                  saturated
);
  localparam int SUM_W = 2*NARROW_W + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (NARROW_W-1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] MIN_V = ~MAX_V;

  logic signed [SUM_W-1:0] extElt, roundBit, sum, shifted;

  always_comb begin
    extElt   = {wideElt[2*NARROW_W-1], wideElt};
    roundBit = {{(SUM_W-1){1'b0}}, 1'b1} << (shiftAmt - SHIFT_W'(1));
    sum      = extElt + roundBit;
    shifted  = sum >>> shiftAmt;
    if (shifted > MAX_V) begin
      narrowElt = MAX_V[NARROW_W-1:0];
      saturated = 1'b1;
    end else if (shifted < MIN_V) begin
      narrowElt = MIN_V[NARROW_W-1:0];
      saturated = 1'b1;
    end else begin
      narrowElt = shifted[NARROW_W-1:0];
      saturated = 1'b0;
    end
  end
endmodule

// File: rtl/nsu_ctrl.sv
module nsu_ctrl
  import nsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [3:0] sizeImm,
  input  logic [2:0] fracImm,
  input  logic       upperSel,
  input  logic       scalarMode,
  input  logic       satClear,
  input  logic       satAny,
  output nsuCtrl_t   ctrl,
  output logic       satSticky
);
  logic [IMM_W-1:0] immVal, twiceSize, diff;

  always_comb begin
    ctrl.legal   = (sizeImm != 4'b0000) && !sizeImm[3];
    ctrl.sizeIdx = sizeImm[2] ? 2'd2 : (sizeImm[1] ? 2'd1 : 2'd0);
    immVal       = {sizeImm, fracImm};
    twiceSize    = IMM_W'(16) << ctrl.sizeIdx;
    diff         = twiceSize - immVal;
    ctrl.shiftAmt = ctrl.legal ? SHIFT_W'(diff) : SHIFT_W'(1);
    ctrl.upper   = upperSel;
    ctrl.scalar  = scalarMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               satSticky <= 1'b0;
    else if (satClear)                        satSticky <= 1'b0;
    else if (inValid && ctrl.legal && satAny) satSticky <= 1'b1;
  end
endmodule

// File: rtl/nsu_datapath.sv
module nsu_datapath
  import nsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  nsuCtrl_t         ctrl,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] oldDst,
  output logic             satAny,
  output logic             outValid,
  output logic [VEC_W-1:0] dstVec,
  output logic             badEnc,
  output logic             satNow
);
  logic [HALF_W-1:0] vecRes    [SEL_N];
  logic [HALF_W-1:0] scalarRes [SEL_N];
  logic [SEL_N-1:0]  vecSat, scalarSat;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int E     = 8 << s;
    localparam int LANES = HALF_W / E;
    logic [HALF_W-1:0] packedRes;
    logic [LANES-1:0]  laneSat;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      nsu_lane #(.NARROW_W(E), .SHIFT_W(SHIFT_W)) u_lane (
        .wideElt  (srcVec[l*2*E +: 2*E]),
        .shiftAmt (ctrl.shiftAmt),
        .narrowElt(packedRes[l*E +: E]),
        .saturated(laneSat[l])
      );
    end
    assign vecRes[s]    = packedRes;
    assign scalarRes[s] = {{(HALF_W-E){1'b0}}, packedRes[E-1:0]};
    assign vecSat[s]    = |laneSat;
    assign scalarSat[s] = laneSat[0];
  end
  assign vecRes[SEL_N-1]    = '0;
  assign scalarRes[SEL_N-1] = '0;
  assign vecSat[SEL_N-1]    = 1'b0;
  assign scalarSat[SEL_N-1] = 1'b0;

  logic [HALF_W-1:0] narrowed;
  logic [VEC_W-1:0]  newDst;

  always_comb begin
    narrowed = ctrl.scalar ? scalarRes[ctrl.sizeIdx] : vecRes[ctrl.sizeIdx];
    satAny   = ctrl.legal && (ctrl.scalar ? scalarSat[ctrl.sizeIdx] : vecSat[ctrl.sizeIdx]);
    if (!ctrl.legal)                     newDst = oldDst;
    else if (ctrl.upper && !ctrl.scalar) newDst = {narrowed, oldDst[HALF_W-1:0]};
    else                                 newDst = {{HALF_W{1'b0}}, narrowed};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      dstVec   <= '0;
      badEnc   <= 1'b0;
      satNow   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        dstVec <= newDst;
        badEnc <= !ctrl.legal;
        satNow <= satAny;
      end
    end
  end
endmodule

// File: rtl/narrow_shift_unit.sv
module narrow_shift_unit
  import nsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [3:0]       sizeImm,
  input  logic [2:0]       fracImm,
  input  logic             upperSel,
  input  logic             scalarMode,
  input  logic [VEC_W-1:0] oldDst,
  input  logic             satClear,
  output logic             outValid,
  output logic [VEC_W-1:0] dstVec,
  output logic             badEnc,
  output logic             satNow,
  output logic             satSticky
);
  nsuCtrl_t ctrl;
  logic     satAny;

  nsu_ctrl u_ctrl (
    .clk, .rst_n, .inValid, .sizeImm, .fracImm, .upperSel, .scalarMode,
    .satClear, .satAny, .ctrl, .satSticky
  );

  nsu_datapath u_dp (
    .clk, .rst_n, .inValid, .ctrl, .srcVec, .oldDst,
    .satAny, .outValid, .dstVec, .badEnc, .satNow
  );
endmodule

// File: rtl/nsu_checker.sv
module nsu_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic [127:0] srcVec,
  input logic [3:0]   sizeImm,
  input logic [2:0]   fracImm,
  input logic         upperSel,
  input logic         scalarMode,
  input logic [127:0] oldDst,
  input logic         satClear,
  input logic         outValid,
  input logic [127:0] dstVec,
  input logic         badEnc,
  input logic         satNow,
  input logic         satSticky
);
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) inValid |=> outValid);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !inValid |=> !outValid);
  // R2
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && badEnc |-> dstVec == $past(oldDst) && !satNow);
  // R2
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && badEnc && !$past(satClear) |-> satSticky == $past(satSticky));
  // R7
  lower_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !badEnc && !$past(upperSel) |-> dstVec[127:64] == 64'h0);
  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !badEnc && $past(upperSel) && !$past(scalarMode) |-> dstVec[63:0] == $past(oldDst[63:0]));
  // R9
  scalar_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !badEnc && $past(scalarMode) |-> dstVec[127:64] == 64'h0);
  // R5
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && satNow && !$past(satClear) |-> satSticky);
  // R6
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(satSticky) |-> $past(satClear));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n) satClear |=> !satSticky);
endmodule

bind narrow_shift_unit nsu_checker u_chk (.*);

// File: tb/narrow_shift_unit_tb_top.sv
`timescale 1ns/1ps
module narrow_shift_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, upperSel = 1'b0, scalarMode = 1'b0, satClear = 1'b0;
  logic [127:0] srcVec = '0, oldDst = '0;
  logic [3:0] sizeImm = '0;
  logic [2:0] fracImm = '0;
  logic outValid, badEnc, satNow, satSticky;
  logic [127:0] dstVec;

  always #2.5 clk = ~clk;

  narrow_shift_unit dut_i (.*);

  int nRun = 0, nFail = 0;
  logic stickyExp = 1'b0;

  localparam logic [127:0] OLD = {16{8'hA5}};

  typedef struct packed {
    logic [127:0] src;
    logic [3:0]   immh;
    logic [2:0]   immb;
    logic         q;
    logic         scal;
    logic [127:0] exp;
    logic         bad;
    logic         sat;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R1 R3: 8-bit, shift 1, 3 -> 2
    '{{8{16'h0003}}, 4'b0001, 3'b111, 1'b0, 1'b0, {64'h0, 64'h0202020202020202}, 1'b0, 1'b0, 8'd3},
    // R3: -3 -> -1, -1 -> 0 (tie rounds up)
    '{{4{16'hFFFF, 16'hFFFD}}, 4'b0001, 3'b111, 1'b0, 1'b0, {64'h0, 64'h00FF00FF00FF00FF}, 1'b0, 1'b0, 8'd3},
    // R8 R4: high half, positive clamp
    '{{8{16'h7FFF}}, 4'b0001, 3'b111, 1'b1, 1'b0, {64'h7F7F7F7F7F7F7F7F, 64'hA5A5A5A5A5A5A5A5}, 1'b0, 1'b1, 8'd8},
    // R4: exact minimum, no saturation
    '{{8{16'h8000}}, 4'b0001, 3'b000, 1'b0, 1'b0, {64'h0, 64'h8080808080808080}, 1'b0, 1'b0, 8'd4},
    // R4: rounding pushes over maximum
    '{{8{16'h7FFF}}, 4'b0001, 3'b000, 1'b0, 1'b0, {64'h0, 64'h7F7F7F7F7F7F7F7F}, 1'b0, 1'b1, 8'd4},
    // R1: 16-bit, shift 16
    '{{4{32'h00018000}}, 4'b0010, 3'b000, 1'b0, 1'b0, {64'h0, 64'h0002000200020002}, 1'b0, 1'b0, 8'd1},
    // R1 R8: 16-bit, shift 1, high half
    '{{4{32'h00000005}}, 4'b0011, 3'b111, 1'b1, 1'b0, {64'h0003000300030003, 64'hA5A5A5A5A5A5A5A5}, 1'b0, 1'b0, 8'd8},
    // R1: 32-bit, shift 32
    '{{2{64'h0000000180000000}}, 4'b0100, 3'b000, 1'b0, 1'b0, {64'h0, 64'h0000000200000002}, 1'b0, 1'b0, 8'd1},
    // R4: 32-bit negative clamp in lane 1
    '{{64'h8000000000000000, 64'h0000000000000009}, 4'b0111, 3'b111, 1'b0, 1'b0, {64'h0, 64'h8000000000000005}, 1'b0, 1'b1, 8'd4},
    // R2: size field zero
    '{{8{16'h7FFF}}, 4'b0000, 3'b111, 1'b0, 1'b0, OLD, 1'b1, 1'b0, 8'd2},
    // R2: top size bit set
    '{{8{16'h7FFF}}, 4'b1001, 3'b111, 1'b1, 1'b0, OLD, 1'b1, 1'b0, 8'd2},
    // R9: scalar 8-bit, other lanes would clamp
    '{{{7{16'h7FFF}}, 16'h0003}, 4'b0001, 3'b111, 1'b0, 1'b1, 128'h02, 1'b0, 1'b0, 8'd9},
    // R9: scalar 32-bit clamp, upperSel ignored
    '{{64'h7FFFFFFFFFFFFFFF, 64'h0000000100000000}, 4'b0111, 3'b111, 1'b1, 1'b1, 128'h7FFFFFFF, 1'b0, 1'b1, 8'd9}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input vec_t v, input logic clr);
    @(negedge clk);
    srcVec = v.src; sizeImm = v.immh; fracImm = v.immb;
    upperSel = v.q; scalarMode = v.scal; oldDst = OLD;
    inValid = 1'b1; satClear = clr;
    @(posedge clk);
    #1;
    if (clr) stickyExp = 1'b0;
    else if (v.sat && !v.bad) stickyExp = 1'b1;
    @(negedge clk);
    inValid = 1'b0; satClear = 1'b0;
  endtask

  task automatic checkOp(input vec_t v, input string req);
    chk(outValid === 1'b1, "R10", "outValid", 128'(outValid), 128'd1);
    chk(dstVec === v.exp, req, "dstVec", dstVec, v.exp);
    chk(badEnc === v.bad, req, "badEnc", 128'(badEnc), 128'(v.bad));
    chk(satNow === v.sat, req, "satNow", 128'(satNow), 128'(v.sat));
    chk(satSticky === stickyExp, "R5", "satSticky", 128'(satSticky), 128'(stickyExp));
  endtask

  initial begin
    #(200000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(outValid === 1'b0, "R11", "outValid", 128'(outValid), 128'd0);
    chk(dstVec === 128'h0, "R11", "dstVec", dstVec, 128'h0);
    chk(badEnc === 1'b0, "R11", "badEnc", 128'(badEnc), 128'd0);
    chk(satSticky === 1'b0, "R11", "satSticky", 128'(satSticky), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      srcVec = VECS[i].src; sizeImm = VECS[i].immh; fracImm = VECS[i].immb;
      upperSel = VECS[i].q; scalarMode = VECS[i].scal; oldDst = OLD;
      inValid = 1'b1;
      @(posedge clk);
      #1;
      if (VECS[i].sat && !VECS[i].bad) stickyExp = 1'b1;
      checkOp(VECS[i], $sformatf("R%0d", VECS[i].req));
      @(negedge clk);
      inValid = 1'b0;
    end

    // R10: outputs hold while idle, inputs moving
    srcVec = '1; sizeImm = 4'b0001; oldDst = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(outValid === 1'b0, "R10", "idle outValid", 128'(outValid), 128'd0);
    chk(dstVec === VECS[NV-1].exp, "R10", "idle dstVec", dstVec, VECS[NV-1].exp);

    // R6: clear alone
    @(negedge clk);
    satClear = 1'b1;
    @(posedge clk);
    #1;
    stickyExp = 1'b0;
    chk(satSticky === 1'b0, "R6", "clear alone", 128'(satSticky), 128'd0);
    @(negedge clk);
    satClear = 1'b0;

    // R6: clear wins over simultaneous clamp
    runOp(VECS[4], 1'b1);
    chk(satNow === 1'b1, "R6", "satNow with clear", 128'(satNow), 128'd1);
    chk(satSticky === 1'b0, "R6", "clear priority", 128'(satSticky), 128'd0);

    // R5: set then hold across a clean op
    runOp(VECS[0], 1'b0);
    chk(satSticky === 1'b0, "R5", "no clamp", 128'(satSticky), 128'd0);
    runOp(VECS[4], 1'b0);
    chk(satSticky === 1'b1, "R5", "set", 128'(satSticky), 128'd1);
    runOp(VECS[0], 1'b0);
    chk(satSticky === 1'b1, "R5", "held", 128'(satSticky), 128'd1);
    chk(satNow === 1'b0, "R5", "per-op clean", 128'(satNow), 128'd0);

    // R2: illegal op keeps sticky at 1
    runOp(VECS[9], 1'b0);
    chk(satSticky === 1'b1, "R2", "sticky unchanged", 128'(satSticky), 128'd1);
    chk(dstVec === OLD, "R2", "dst unchanged", dstVec, OLD);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule